// File: doc/BRIEF.md
# Dual-Width Instruction Prefetch Queue

This block sits between a processor core's decoder and a 32-bit synchronous code memory. It keeps two upcoming instructions queued ahead of the one being executed. The core runs either full 32-bit instructions or compressed 16-bit instructions. A redirect (branch) picks the state from bit 0 of the target, aligns the address, sets the program counter and refills the queue. A step hands the head of the queue to the core and shifts the queue. A counter records every code-memory read, so the core can account for fetch cost.

In 16-bit state one 32-bit read carries two instructions. After a step that lands on the upper halfword of the word already held, the queue refills itself by shifting and skips the memory access. A return from an exception can make the saved status word's state flag, rather than the target's bit 0, select the state.

The memory answers one cycle after a request: `mem_rdata_i` holds the word for the address presented in the previous cycle. A redirect has priority over a step. A step is taken only while `ready_o` is high.

Top module: `dual_width_prefetch`

## Requirements
- R1: On a redirect, the effective bit 0 selects the state. When it is 1, `half_mode_o` becomes 1 and `pc_o` becomes (target with bit 0 cleared) + 2. When it is 0, `half_mode_o` becomes 0 and `pc_o` becomes (target with bits 1:0 cleared) + 4. `pc_o` takes its new value on the clock edge that samples the redirect.
- R2: A redirect into 32-bit state reads the words at the aligned target A and at A+4, in that order. The first step then delivers the word at A and the second step delivers the word at A+4. The fetch counter rises by 2.
- R3: A redirect into 16-bit state whose aligned target A has bit 1 set reads the word at A-2 and then the word at A+2. Queue entry 0 takes the upper halfword of the first word and entry 1 takes the second word. The fetch counter rises by 2.
- R4: A redirect into 16-bit state whose aligned target A has bit 1 clear reads only the word at A. Entry 0 takes that word and entry 1 takes the same word shifted right by 16. The fetch counter rises by 1.
- R5: An accepted step moves `pc_o` forward by 2 in 16-bit state and by 4 in 32-bit state. Entry 0 becomes `instr_o`, and entry 1 moves into entry 0. After the step, `instr_o` is the instruction at (new `pc_o`) − 2×increment. In 16-bit state only `instr_o[15:0]` is meaningful.
- R6: In 16-bit state, a step whose new `pc_o` has bit 1 set issues no memory read and leaves the fetch counter unchanged. Entry 1 is refilled with the old entry 1 shifted right by 16.
- R7: Any other step reads the word at the new `pc_o` into entry 1 and raises the fetch counter by 1. Every address the block presents has bits 1:0 equal to 0.
- R8: When `br_restore_i` is high, `br_saved_half_i` replaces target bit 0 in R1: 1 selects 16-bit state and 0 selects 32-bit state.
- R9: After a redirect, `instr_valid_o` and `ready_o` are low until the refill completes. A step while `ready_o` is low is ignored. A step in the same cycle as a redirect is ignored. `instr_valid_o` rises with the first accepted step after the refill.
- R10: After reset, `ready_o`, `instr_valid_o`, `mem_req_o`, `half_mode_o`, `pc_o` and `fetch_cycles_o` are all 0. Steps are ignored until the first redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid_i | input | 1 | Redirect request |
| br_target_i | input | ADDR_W | Redirect target address |
| br_restore_i | input | 1 | Take the state from `br_saved_half_i` instead of target bit 0 |
| br_saved_half_i | input | 1 | State flag from the saved status word |
| step_i | input | 1 | Sequential advance request |
| mem_req_o | output | 1 | Code-memory read request |
| mem_addr_o | output | ADDR_W | Word-aligned read address |
| mem_rdata_i | input | DATA_W | Read data, one cycle after the request |
| ready_o | output | 1 | Queue full; a step is accepted |
| instr_o | output | DATA_W | Current instruction |
| instr_valid_o | output | 1 | `instr_o` holds a delivered instruction |
| pc_o | output | ADDR_W | Program counter |
| half_mode_o | output | 1 | 1 = 16-bit state, 0 = 32-bit state |
| fetch_cycles_o | output | CNT_W | Count of code-memory reads, wrapping |

## Verification
A wrong queue entry or a wrong shift stays hidden until the step that moves that entry to `instr_o`. That is one step after a redirect for entry 0 and two steps for entry 1. The bench therefore steps at least twice after every kind of redirect and compares every delivered instruction against its address. A wrong fetch decision shows at once on `fetch_cycles_o`, in the cycle after the step or redirect that caused it. A wrong program counter shows on `pc_o` on the very next edge.

// File: rtl/ipq_pkg.sv
// Shared types for the dual-width prefetch queue.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ipq_pkg;

    // Queue controller states
    typedef enum logic [2:0] {
        ST_IDLE,     // no valid stream since reset
        ST_RUN,      // queue full, steps accepted
        ST_CAP0,     // capturing the first refill word
        ST_CAP1,     // capturing the second refill word
        ST_CAPS      // capturing the word a step asked for
    } ipq_state_e;

    // How a redirect refills the queue
    typedef enum logic [1:0] {
        FK_WORD_PAIR,   // 32-bit state: two consecutive words
        FK_HALF_SPLIT,  // 16-bit state, odd halfword: upper half + next word
        FK_HALF_SHARED  // 16-bit state, even halfword: one word feeds both
    } ipq_fill_e;

endpackage

// File: rtl/ipq_target_align.sv
// Redirect decoder: picks the state, aligns the target, and derives the
// initial program counter, the refill kind and both refill addresses.
// Assumes byte addresses and 32-bit code words. Purely combinational.
module ipq_target_align #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] target_i,
    input  logic              restore_i,
    input  logic              saved_half_i,
    output logic              half_o,
    output logic [ADDR_W-1:0] pc_init_o,
    output logic [ADDR_W-1:0] addr_first_o,
    output logic [ADDR_W-1:0] addr_second_o,
    output ipq_pkg::ipq_fill_e kind_o
);
    import ipq_pkg::*;

    localparam logic [ADDR_W-1:0] HSTEP = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(4);

    logic [ADDR_W-1:0] aligned;

    // Select state and aligned address
    always_comb begin
        half_o  = restore_i ? saved_half_i : target_i[0];
        aligned = half_o ? {target_i[ADDR_W-1:1], 1'b0}
                         : {target_i[ADDR_W-1:2], 2'b00};
        pc_init_o = aligned + (half_o ? HSTEP : WSTEP);
    end

    // Choose refill pattern and its two addresses
    always_comb begin
        if (!half_o)
            kind_o = FK_WORD_PAIR;
        else if (aligned[1])
            kind_o = FK_HALF_SPLIT;
        else
            kind_o = FK_HALF_SHARED;
        addr_first_o  = (kind_o == FK_HALF_SPLIT) ? aligned - HSTEP : aligned;
        addr_second_o = (kind_o == FK_HALF_SPLIT) ? aligned + HSTEP : aligned + WSTEP;
    end

endmodule

// File: rtl/ipq_step_calc.sv
// Sequential-step helper: next program counter and whether the step
// needs a new memory word. Assumes pc_i is aligned for its state.
module ipq_step_calc #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              half_i,
    output logic [ADDR_W-1:0] pc_next_o,
    output logic              need_fetch_o
);
    localparam logic [ADDR_W-1:0] HSTEP = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(4);

    // Advance and decide on a fetch
    always_comb begin
        pc_next_o    = pc_i + (half_i ? HSTEP : WSTEP);
        need_fetch_o = !half_i || !pc_next_o[1];
    end

endmodule

// File: rtl/ipq_fetch_counter.sv
// Counts code-memory reads. Wraps at 2**CNT_W. Synchronous active-low reset.
module ipq_fetch_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    // Accumulate one per read
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_o <= '0;
        else if (inc_i)
            count_o <= count_o + CNT_W'(1);
    end

endmodule

// File: rtl/dual_width_prefetch.sv
// Two-entry instruction prefetch queue for a core with 32-bit and 16-bit
// instruction states, fed by a 32-bit synchronous code memory (data one
// cycle after the request). A redirect refills the queue; a step shifts it
// and fetches only when a new word is needed. Redirect beats step.
// Assumes DATA_W is twice the compressed instruction width.
module dual_width_prefetch #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid_i,
    input  logic [ADDR_W-1:0] br_target_i,
    input  logic              br_restore_i,
    input  logic              br_saved_half_i,
    input  logic              step_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] instr_o,
    output logic              instr_valid_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              half_mode_o,
    output logic [CNT_W-1:0]  fetch_cycles_o
);
    import ipq_pkg::*;

    localparam int HALF_W = DATA_W / 2;

    ipq_state_e        st_q;
    ipq_fill_e         kind_q;
    logic [ADDR_W-1:0] pc_q;
    logic              half_q;
    logic [DATA_W-1:0] q0_q, q1_q, cur_q;
    logic              cur_v_q;
    logic [ADDR_W-1:0] addr2_q;

    logic              br_half;
    logic [ADDR_W-1:0] br_pc, br_a1, br_a2;
    ipq_fill_e         br_kind;
    logic [ADDR_W-1:0] pc_next;
    logic              need_fetch;
    logic              step_go;
    logic [DATA_W-1:0] rd_hi, q1_hi;

    ipq_target_align #(.ADDR_W(ADDR_W)) u_align (
        .target_i      (br_target_i),
        .restore_i     (br_restore_i),
        .saved_half_i  (br_saved_half_i),
        .half_o        (br_half),
        .pc_init_o     (br_pc),
        .addr_first_o  (br_a1),
        .addr_second_o (br_a2),
        .kind_o        (br_kind)
    );

    ipq_step_calc #(.ADDR_W(ADDR_W)) u_step (
        .pc_i         (pc_q),
        .half_i       (half_q),
        .pc_next_o    (pc_next),
        .need_fetch_o (need_fetch)
    );

    ipq_fetch_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (mem_req_o),
        .count_o (fetch_cycles_o)
    );

    // Step acceptance and upper-half extracts
    always_comb begin
        step_go = (st_q == ST_RUN) && step_i && !br_valid_i;
        rd_hi   = {{HALF_W{1'b0}}, mem_rdata_i[DATA_W-1:HALF_W]};
        q1_hi   = {{HALF_W{1'b0}}, q1_q[DATA_W-1:HALF_W]};
    end

    // Memory request: redirect first, then step, then second refill word
    always_comb begin
        mem_req_o  = 1'b0;
        mem_addr_o = addr2_q;
        if (br_valid_i) begin
            mem_req_o  = 1'b1;
            mem_addr_o = br_a1;
        end else if (step_go) begin
            mem_req_o  = need_fetch;
            mem_addr_o = pc_next;
        end else if (st_q == ST_CAP0 && kind_q != FK_HALF_SHARED) begin
            mem_req_o  = 1'b1;
        end
    end

    // Queue, program counter and state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            kind_q  <= FK_WORD_PAIR;
            pc_q    <= '0;
            half_q  <= 1'b0;
            q0_q    <= '0;
            q1_q    <= '0;
            cur_q   <= '0;
            cur_v_q <= 1'b0;
            addr2_q <= '0;
        end else if (br_valid_i) begin
            st_q    <= ST_CAP0;
            kind_q  <= br_kind;
            pc_q    <= br_pc;
            half_q  <= br_half;
            addr2_q <= br_a2;
            cur_v_q <= 1'b0;
        end else begin
            case (st_q)
                ST_RUN: if (step_i) begin
                    cur_q   <= q0_q;
                    cur_v_q <= 1'b1;
                    q0_q    <= q1_q;
                    pc_q    <= pc_next;
                    if (need_fetch) st_q <= ST_CAPS;
                    else            q1_q <= q1_hi;
                end
                ST_CAP0: begin
                    q0_q <= (kind_q == FK_HALF_SPLIT) ? rd_hi : mem_rdata_i;
                    if (kind_q == FK_HALF_SHARED) begin
                        q1_q <= rd_hi;
                        st_q <= ST_RUN;
                    end else begin
                        st_q <= ST_CAP1;
                    end
                end
                ST_CAP1, ST_CAPS: begin
                    q1_q <= mem_rdata_i;
                    st_q <= ST_RUN;
                end
                default: ;
            endcase
        end
    end

    // Output mapping
    always_comb begin
        ready_o       = (st_q == ST_RUN);
        instr_o       = cur_q;
        instr_valid_o = cur_v_q;
        pc_o          = pc_q;
        half_mode_o   = half_q;
    end

    // R1
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |-> (half_q ? (pc_q[0] == 1'b0) : (pc_q[1:0] == 2'b00)));

    // R5
    step_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_go |=> (pc_o == $past(pc_o) + (($past(half_mode_o)) ? ADDR_W'(2) : ADDR_W'(4))));

    // R6
    half_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_go && half_q && !pc_q[1]) |-> !mem_req_o);

    // R7
    word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    // R9
    refill_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid_i |=> (!ready_o && !instr_valid_o));

    // R9
    refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CAP0 || st_q == ST_CAP1) |-> !instr_valid_o);

endmodule

// File: tb/dual_width_prefetch_test.sv
module dual_width_prefetch_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        br_valid_i, br_restore_i, br_saved_half_i, step_i;
    logic [31:0] br_target_i;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic [31:0] mem_rdata_i;
    logic        ready_o, instr_valid_o, half_mode_o;
    logic [31:0] instr_o, pc_o;
    logic [15:0] fetch_cycles_o;

    always #10 clk = ~clk;

    dual_width_prefetch uut (
        .clk(clk), .rst_n(rst_n),
        .br_valid_i(br_valid_i), .br_target_i(br_target_i),
        .br_restore_i(br_restore_i), .br_saved_half_i(br_saved_half_i),
        .step_i(step_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_rdata_i(mem_rdata_i), .ready_o(ready_o), .instr_o(instr_o),
        .instr_valid_o(instr_valid_o), .pc_o(pc_o), .half_mode_o(half_mode_o),
        .fetch_cycles_o(fetch_cycles_o)
    );

    // Code memory: every halfword address has a distinct code
    function automatic logic [15:0] code16(input logic [31:0] a);
        return a[15:0] ^ 16'hC3A5;
    endfunction
    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {code16(a + 32'd2), code16(a)};
    endfunction

    always_ff @(posedge clk) begin
        if (mem_req_o) mem_rdata_i <= word_at(mem_addr_o);
    end

    int checks = 0;
    int fails  = 0;

    function automatic void chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    typedef struct {
        logic [31:0] iaddr;
        logic        half;
        logic [31:0] pc;
    } exp_t;
    exp_t sb[$];

    logic        fired;
    logic [31:0] m_pc;
    logic        m_half;

    always_ff @(posedge clk) begin
        if (!rst_n) fired <= 1'b0;
        else        fired <= step_i && ready_o && !br_valid_i;
    end

    // Monitor: compare each delivered instruction against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (fired) begin
                if (sb.size() == 0) begin
                    chk("R9 unexpected step accepted", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.half)
                        chk("R5 instr low half", {16'h0, instr_o[15:0]}, {16'h0, code16(e.iaddr)});
                    else
                        chk("R5 instr word", instr_o, word_at(e.iaddr));
                    chk("R5 pc", pc_o, e.pc);
                    chk("R9 valid after step", {31'h0, instr_valid_o}, 32'd1);
                end
            end
        end
    end

    task automatic do_branch(input logic [31:0] t, input bit rest, input bit saved,
                             input int exp_fetch, input bit hold_step, input string tag);
        int c0;
        logic [31:0] al;
        logic h;
        @(negedge clk);
        c0 = fetch_cycles_o;
        br_valid_i = 1'b1; br_target_i = t; br_restore_i = rest; br_saved_half_i = saved;
        step_i = hold_step;
        h = rest ? saved : t[0];
        al = h ? (t & ~32'd1) : (t & ~32'd3);
        m_pc = al + (h ? 32'd2 : 32'd4);
        m_half = h;
        @(negedge clk);
        br_valid_i = 1'b0; br_restore_i = 1'b0;
        chk({tag, " R9 valid low in refill"}, {31'h0, instr_valid_o}, 32'd0);
        chk({tag, " R9 not ready in refill"}, {31'h0, ready_o}, 32'd0);
        chk({tag, " R1 pc"}, pc_o, m_pc);
        chk({tag, " R1 state"}, {31'h0, half_mode_o}, {31'h0, h});
        for (int i = 0; i < 8 && !ready_o; i++) @(negedge clk);
        step_i = 1'b0;
        chk({tag, " refill done"}, {31'h0, ready_o}, 32'd1);
        chk({tag, " fetch count"}, 32'(fetch_cycles_o - 16'(c0)), 32'(exp_fetch));
        if (hold_step) chk("R9 pc unchanged by ignored step", pc_o, m_pc);
    endtask

    task automatic do_step(input string tag);
        int c0;
        logic [31:0] inc;
        bit need;
        exp_t e;
        @(negedge clk);
        while (!ready_o) @(negedge clk);
        c0 = fetch_cycles_o;
        step_i = 1'b1;
        inc = m_half ? 32'd2 : 32'd4;
        m_pc = m_pc + inc;
        need = !m_half || !m_pc[1];
        e.iaddr = m_pc - 2 * inc; e.half = m_half; e.pc = m_pc;
        sb.push_back(e);
        @(negedge clk);
        step_i = 1'b0;
        chk({tag, need ? " R7 step fetch" : " R6 step no fetch"},
            32'(fetch_cycles_o - 16'(c0)), need ? 32'd1 : 32'd0);
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; br_valid_i = 1'b0; br_target_i = '0; br_restore_i = 1'b0;
        br_saved_half_i = 1'b0; step_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state, and steps ignored before any redirect
        step_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 ready", {31'h0, ready_o}, 32'd0);
        chk("R10 valid", {31'h0, instr_valid_o}, 32'd0);
        chk("R10 mem_req", {31'h0, mem_req_o}, 32'd0);
        chk("R10 count", {16'h0, fetch_cycles_o}, 32'd0);
        chk("R10 pc", pc_o, 32'd0);
        chk("R10 state", {31'h0, half_mode_o}, 32'd0);
        step_i = 1'b0;

        do_branch(32'h0000_0100, 1'b0, 1'b0, 2, 1'b0, "R2");
        for (int i = 0; i < 4; i++) do_step("R2");
        do_branch(32'h0000_010E, 1'b0, 1'b0, 2, 1'b0, "R1");
        for (int i = 0; i < 2; i++) do_step("R1");
        do_branch(32'h0000_0201, 1'b0, 1'b0, 1, 1'b0, "R4");
        for (int i = 0; i < 5; i++) do_step("R4");
        do_branch(32'h0000_0307, 1'b0, 1'b0, 2, 1'b0, "R3");
        for (int i = 0; i < 5; i++) do_step("R3");
        do_branch(32'h0000_0401, 1'b1, 1'b0, 2, 1'b0, "R8");
        for (int i = 0; i < 3; i++) do_step("R8");
        do_branch(32'h0000_0500, 1'b1, 1'b1, 1, 1'b0, "R8");
        for (int i = 0; i < 3; i++) do_step("R8");
        do_branch(32'h0000_0602, 1'b0, 1'b0, 2, 1'b1, "R9");
        for (int i = 0; i < 2; i++) do_step("R9");

        repeat (3) @(negedge clk);
        chk("R5 scoreboard drained", 32'(sb.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule